// File: doc/BRIEF.md
# Value-Gated Parallel-Prefix Adder

This block is a registered 32-bit adder with a Kogge-Stone carry network in which every bit column of the upper half can be put to sleep. The operand-pair stage forms the usual propagate (XOR) and generate (AND) terms for each column, plus the OR of the two operand bits. In the upper half that OR becomes the column's wake signal. When both operand bits of an upper column are zero, the column sleeps: its generate, its propagate and every prefix node in that column are forced to zero. Because those values would be zero anyway, the result is still exact. The lower half is never gated.

The wake signals are decoded straight from the registered operands. There is no prediction and no history, and waking a column never costs a cycle. Alongside the sum and the carry-out, the block reports the wake vector of the upper columns and a count of sleeping columns. Power management uses that count as a cheap proxy for leakage.

Operands and carry-in are captured on one rising edge, and the results are registered on the next. A new operation can be accepted every cycle.

Top module: `vgpa_adder`

## Requirements
- R1: Two rising edges after operands are presented, `sum` equals (op_a + op_b + carry_in) modulo 2^32, and a new operand set is accepted on every cycle.
- R2: `carry_out` equals bit 32 of the full-precision op_a + op_b + carry_in, with the same two-edge latency.
- R3: `slice_en[k]` equals op_a[16+k] OR op_b[16+k] (bit 0 of the vector belongs to operand bit 16), with the same two-edge latency.
- R4: `sleep_cnt` equals the number of positions k in 16..31 where both op_a[k] and op_b[k] are zero. It is 16 when the upper halves of both operands are zero and 0 when every upper pair has a one.
- R5: A carry that enters a sleeping upper column from below appears unchanged as that column's sum bit. For example, 0x0000FFFF + 0x00000001 gives 0x00010000 with carry_out 0.
- R6: While `rst` is high on a rising edge, the outputs read sum 0, carry_out 0, slice_en 0 and sleep_cnt 16 after that edge, whatever the operand inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Registered sum |
| carry_out | output | 1 | Registered carry out of bit 31 |
| slice_en | output | 16 | Registered wake vector of columns 16..31 |
| sleep_cnt | output | 5 | Registered count of sleeping upper columns |

## Verification
A column wrongly left asleep, or a prefix node gated in the wrong column, removes a carry or a propagate term. That error shows two edges later as a wrong sum bit at or above the faulty column, and often as a wrong carry_out as well. Such faults only show up when a carry must cross a sleeping column. Stimulus therefore sweeps 0 to 16 zero upper pairs, feeds carries from the lower half into empty upper halves, and includes sign-extended small values. A miscounted or misrouted wake bit shows in the same cycle as a mismatch between slice_en and sleep_cnt and the operands captured two edges earlier.

// File: rtl/vgpa_pkg.sv
package vgpa_pkg;
   // Default geometry of the adder; modules take these as parameter defaults.
   localparam int unsigned VGPA_WIDTH = 32;
   localparam int unsigned VGPA_GATED = 16;

   // Width of a counter able to hold 0..n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/vgpa_bitpair.sv
// Operand-pair stage: propagate, generate and (upper half only) a wake bit.
// Column index is shifted by one; column 0 carries the external carry-in.
module vgpa_bitpair #(
   parameter int unsigned WIDTH = vgpa_pkg::VGPA_WIDTH,
   parameter int unsigned GATED = vgpa_pkg::VGPA_GATED
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH:0]   gen,
   output logic [WIDTH:0]   prop,
   output logic [WIDTH:0]   awake,
   output logic [GATED-1:0] en_hi
);
   localparam int unsigned LOW_COLS = WIDTH - GATED;

   assign gen[0]   = cin;
   assign prop[0]  = 1'b0;
   assign awake[0] = 1'b1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_col
      logic x_bit;
      logic n_bit;
      assign x_bit = a[i] ^ b[i];
      assign n_bit = a[i] & b[i];
      if (i >= LOW_COLS) begin : g_gated
         logic o_bit;
         assign o_bit              = a[i] | b[i];
         assign en_hi[i-LOW_COLS]  = o_bit;
         assign awake[i+1]         = o_bit;
         // Sleeping column: outputs strapped to zero.
         assign gen[i+1]           = o_bit & n_bit;
         assign prop[i+1]          = o_bit & x_bit;
      end else begin : g_always_on
         assign awake[i+1] = 1'b1;
         assign gen[i+1]   = n_bit;
         assign prop[i+1]  = x_bit;
      end
   end
endmodule

// File: rtl/vgpa_prefix.sv
// Kogge-Stone prefix network over WIDTH+1 columns. Every node of a sleeping
// column drives zero, which equals its true group value in that case.
module vgpa_prefix #(
   parameter int unsigned WIDTH = vgpa_pkg::VGPA_WIDTH
) (
   input  logic [WIDTH:0] gen,
   input  logic [WIDTH:0] prop,
   input  logic [WIDTH:0] awake,
   output logic [WIDTH:0] grp
);
   localparam int unsigned COLS   = WIDTH + 1;
   localparam int unsigned LEVELS = $clog2(COLS);

   logic [LEVELS:0][COLS-1:0]   gl;
   logic [LEVELS-1:0][COLS-1:0] pl;

   assign gl[0] = gen;
   assign pl[0] = prop;

   for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
      localparam int unsigned DIST = 1 << (l - 1);
      for (genvar j = 0; j < COLS; j++) begin : g_node
         if (j >= DIST) begin : g_merge
            assign gl[l][j] = awake[j] &
                              (gl[l-1][j] | (pl[l-1][j] & gl[l-1][j-DIST]));
            if (l < LEVELS) begin : g_p
               assign pl[l][j] = awake[j] & pl[l-1][j] & pl[l-1][j-DIST];
            end
         end else begin : g_pass
            assign gl[l][j] = awake[j] & gl[l-1][j];
            if (l < LEVELS) begin : g_p
               assign pl[l][j] = awake[j] & pl[l-1][j];
            end
         end
      end
   end

   assign grp = gl[LEVELS];
endmodule

// File: rtl/vgpa_sleep_count.sv
// Counts the sleeping upper columns.
module vgpa_sleep_count #(
   parameter int unsigned GATED = vgpa_pkg::VGPA_GATED,
   localparam int unsigned CW   = vgpa_pkg::cnt_width(GATED)
) (
   input  logic [GATED-1:0] en_hi,
   output logic [CW-1:0]    cnt
);
   always_comb begin
      cnt = '0;
      for (int k = 0; k < GATED; k++) begin
         if (!en_hi[k]) cnt = cnt + 1'b1;
      end
   end
endmodule

// File: rtl/vgpa_adder.sv
module vgpa_adder #(
   parameter int unsigned WIDTH = vgpa_pkg::VGPA_WIDTH,
   parameter int unsigned GATED = vgpa_pkg::VGPA_GATED,
   localparam int unsigned CW   = vgpa_pkg::cnt_width(GATED)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic [GATED-1:0] slice_en,
   output logic [CW-1:0]    sleep_cnt
);
   if (WIDTH < 2) begin : g_bad_width
      $error("vgpa_adder: WIDTH must be at least 2");
   end
   if (GATED < 1 || GATED > WIDTH) begin : g_bad_gated
      $error("vgpa_adder: GATED must lie in 1..WIDTH");
   end

   logic [WIDTH-1:0] a_q, b_q;
   logic             c_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
         c_q <= 1'b0;
      end else begin
         a_q <= op_a;
         b_q <= op_b;
         c_q <= carry_in;
      end
   end

   logic [WIDTH:0]   gen, prop, awake, grp;
   logic [GATED-1:0] en_hi;
   logic [CW-1:0]    cnt;
   logic [WIDTH-1:0] sum_d;

   vgpa_bitpair #(.WIDTH(WIDTH), .GATED(GATED)) u_pair (
      .a(a_q), .b(b_q), .cin(c_q),
      .gen(gen), .prop(prop), .awake(awake), .en_hi(en_hi)
   );

   vgpa_prefix #(.WIDTH(WIDTH)) u_tree (
      .gen(gen), .prop(prop), .awake(awake), .grp(grp)
   );

   vgpa_sleep_count #(.GATED(GATED)) u_cnt (
      .en_hi(en_hi), .cnt(cnt)
   );

   // Sum bit i: column propagate XOR carry from all columns below.
   for (genvar i = 0; i < WIDTH; i++) begin : g_sum
      assign sum_d[i] = prop[i+1] ^ grp[i];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum       <= '0;
         carry_out <= 1'b0;
         slice_en  <= '0;
         sleep_cnt <= CW'(GATED);
      end else begin
         sum       <= sum_d;
         carry_out <= grp[WIDTH];
         slice_en  <= en_hi;
         sleep_cnt <= cnt;
      end
   end
endmodule

// File: rtl/vgpa_adder_checker.sv
module vgpa_adder_checker #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned GATED = 16,
   localparam int unsigned CW   = $clog2(GATED + 1)
) (
   input logic             clk,
   input logic             rst,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic             carry_in,
   input logic [WIDTH-1:0] sum,
   input logic             carry_out,
   input logic [GATED-1:0] slice_en,
   input logic [CW-1:0]    sleep_cnt
);
   logic [1:0]       age;
   logic             rst_q = 1'b0;
   logic [WIDTH-1:0] a_d1, a_d2, b_d1, b_d2;
   logic             c_d1, c_d2;
   logic [WIDTH:0]   want;
   logic [GATED-1:0] want_en;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      a_d1 <= op_a;     a_d2 <= a_d1;
      b_d1 <= op_b;     b_d2 <= b_d1;
      c_d1 <= carry_in; c_d2 <= c_d1;
      if (rst)            age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   assign want    = {1'b0, a_d2} + {1'b0, b_d2} + {{WIDTH{1'b0}}, c_d2};
   assign want_en = a_d2[WIDTH-1:WIDTH-GATED] | b_d2[WIDTH-1:WIDTH-GATED];

   AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2) |-> (sum == want[WIDTH-1:0])); // R1
   AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2) |-> (carry_out == want[WIDTH])); // R2
   AST_WAKE_MATCH: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2) |-> (slice_en == want_en)); // R3
   AST_SLEEP_COUNT: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2) |-> (sleep_cnt == CW'($countones(~want_en)))); // R4
   AST_RESET_STATE: assert property (@(posedge clk)
      rst_q |-> (sum == '0 && !carry_out && slice_en == '0 &&
                 sleep_cnt == CW'(GATED))); // R6
endmodule

bind vgpa_adder vgpa_adder_checker #(.WIDTH(WIDTH), .GATED(GATED)) u_vgpa_chk (
   .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
   .sum(sum), .carry_out(carry_out), .slice_en(slice_en), .sleep_cnt(sleep_cnt)
);

// File: tb/vgpa_adder_bench.sv
module vgpa_adder_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] op_a = '0, op_b = '0;
   logic        carry_in = 1'b0;
   logic [31:0] sum;
   logic        carry_out;
   logic [15:0] slice_en;
   logic [4:0]  sleep_cnt;

   int n_checks = 0;
   int n_fail   = 0;

   // Expectation pipeline: slot 1 = driven last step, slot 2 = due now.
   logic        v1 = 1'b0, v2 = 1'b0;
   logic [31:0] a1, b1, a2, b2;
   logic        c1, c2;
   string       t1, t2;

   always #(CLK_PERIOD/2) clk = ~clk;

   vgpa_adder u_vgpa_adder (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .sum(sum), .carry_out(carry_out), .slice_en(slice_en), .sleep_cnt(sleep_cnt)
   );

   function automatic logic [32:0] ref_total(logic [31:0] a, logic [31:0] b, logic c);
      return {1'b0, a} + {1'b0, b} + {32'd0, c};
   endfunction

   function automatic int ref_sleep(logic [31:0] a, logic [31:0] b);
      int z = 0;
      for (int k = 16; k < 32; k++) if (!a[k] && !b[k]) z++;
      return z;
   endfunction

   task automatic chk(string req, string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
      end
   endtask

   // Called at a negedge: check what is due, then drive new operands.
   task automatic step(logic [31:0] a, logic [31:0] b, logic c, string tag);
      logic [32:0] t;
      if (v2) begin
         t = ref_total(a2, b2, c2);
         chk("R1", t2, 64'(sum), 64'(t[31:0]));
         chk("R2", t2, 64'(carry_out), 64'(t[32]));
         chk("R3", t2, 64'(slice_en), 64'(a2[31:16] | b2[31:16]));
         chk("R4", t2, 64'(sleep_cnt), 64'(ref_sleep(a2, b2)));
      end
      v2 = v1; a2 = a1; b2 = b1; c2 = c1; t2 = t1;
      v1 = 1'b1; a1 = a; b1 = b; c1 = c; t1 = tag;
      op_a = a; op_b = b; carry_in = c;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      // R6: reset state, also with nonzero operands presented during reset.
      op_a = 32'hFFFF_FFFF; op_b = 32'h1234_5678; carry_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6", "reset", 64'(sum), 64'd0);
      chk("R6", "reset", 64'(carry_out), 64'd0);
      chk("R6", "reset", 64'(slice_en), 64'd0);
      chk("R6", "reset", 64'(sleep_cnt), 64'd16);
      rst = 1'b0;

      // Directed corners.
      step(32'h0000_0000, 32'h0000_0000, 1'b0, "R4 all asleep");
      step(32'h0000_0000, 32'h0000_0000, 1'b1, "R5 cin into empty word");
      step(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R5 carry into sleeping bit16");
      step(32'h0000_FFFF, 32'h0000_0000, 1'b1, "R5 cin ripples to bit16");
      step(32'h7FFF_FFFF, 32'h0000_0000, 1'b1, "R5 carry into top");
      step(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R2 wrap");
      step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2 max");
      step(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 top pair only");
      step(32'hFFFF_0000, 32'h0000_0000, 1'b0, "R4 none asleep");

      // R4 sweep: exactly z sleeping upper columns (the top z).
      for (int z = 0; z <= 16; z++) begin
         logic [31:0] keep, ones, a, b;
         keep = (z == 16) ? 32'h0000_FFFF : (32'hFFFF_FFFF >> z);
         ones = keep & 32'hFFFF_0000;
         a = ($urandom() & keep) | ones;
         b = $urandom() & keep;
         step(a, b, 1'($urandom()), "R4 sweep");
         step(a & 32'h0000_FFFF | (32'h0000_FFFF & 32'hFFFF), b, 1'b1, "R5 sweep low");
      end

      // Sign-extended small values (R1, R5).
      for (int n = 0; n < 60; n++) begin
         int sa, sb;
         sa = int'($urandom_range(2000)) - 1000;
         sb = int'($urandom_range(2000)) - 1000;
         step(32'(sa), 32'(sb), 1'($urandom()), "R1 sign-extended");
      end

      // Unconstrained random, back to back (R1 throughput).
      for (int n = 0; n < 300; n++) begin
         step($urandom(), $urandom(), 1'($urandom()), "R1 random");
      end

      // Flush the pipeline.
      step('0, '0, 1'b0, "flush");
      step('0, '0, 1'b0, "flush");
      step('0, '0, 1'b0, "flush");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule